// File: doc/BRIEF.md
# Per-Thread Return Address Stack with Repair

This block holds predicted return addresses for a speculative fetch unit. A predicted call pushes the address of the instruction after it. A predicted return pops, and the target it uses is the entry on top. Each hardware thread has its own circular stack of sixteen entries, and a thread id input selects which stack the current cycle's request applies to and which stack the outputs show. When the stack overflows, the pointer wraps and the oldest entry is overwritten.

The outputs always show the selected stack as it was before the current cycle's operation. A fetch stage that pops for a return therefore sees the target and the index it needs to save in the same cycle. Repair needs no copy of the stack. A mispredicted return is undone by a restore operation, which puts the saved index back into the top pointer and writes the saved target back into that slot. A mispredicted call is undone by a plain pop. The caller is responsible for applying repairs in the correct order.

Top module: `ras_repair_top`

## Requirements
- R1: After reset every thread's top index is 0 and its top address is 0.
- R2: A push alone (push_en=1, pop_en=1'b0, fix_en=0) advances the selected thread's top index by one modulo 16. In the next cycle top_addr equals the pushed address.
- R3: A pop alone moves the selected thread's top index back by one modulo 16. In the next cycle top_addr shows the entry below, or whatever that slot last held.
- R4: top_addr and top_idx show the selected thread's state from before the current cycle's operation, so a pop reports the target and index it removes.
- R5: When push and pop are requested together, the pop is applied first and then the push. The top index is unchanged and the top entry is replaced by the pushed address.
- R6: A restore (fix_en=1) sets the selected thread's top index to fix_idx and writes fix_addr into that slot. It takes priority over any push or pop in the same cycle.
- R7: After more than 16 pushes the index wraps from 15 to 0 and the oldest entries are overwritten. Popping back from index 0 wraps to 15.
- R8: An operation changes only the stack selected by thr_id. Every other thread's index and entries are left unchanged.
- R9: A cycle with no operation leaves the selected stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_id | input | 1 | Thread selecting the stack that is operated on and shown |
| push_en | input | 1 | Push a call return address |
| push_addr | input | 32 | Address to push |
| pop_en | input | 1 | Pop for a return, or to undo a call |
| fix_en | input | 1 | Restore a saved index and target |
| fix_idx | input | 4 | Saved top index to restore |
| fix_addr | input | 32 | Saved target to write into the restored slot |
| top_addr | output | 32 | Top entry of the selected stack |
| top_idx | output | 4 | Top index of the selected stack |

## Verification
A wrong pointer update appears on top_idx in the very next cycle on which its thread is selected. A wrong entry write shows on top_addr only when the pointer next lands on that slot, which can be many pushes and pops later. For that reason the reference model is compared on every cycle, including long push runs that wrap and pop runs that read overwritten slots. A leak between threads shows only once the bench switches back to the other thread, so the sequences move between threads in the middle of operations.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int unsigned RAS_DEPTH  = 16;
  localparam int unsigned RAS_PTR_W  = $clog2(RAS_DEPTH);
  localparam int unsigned RAS_ADDR_W = 32;

  typedef logic [RAS_PTR_W-1:0]  ras_ptr_t;
  typedef logic [RAS_ADDR_W-1:0] ras_addr_t;

  // circular successor of a stack index
  function automatic ras_ptr_t ptr_next(input ras_ptr_t p);
    if (p == ras_ptr_t'(RAS_DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // circular predecessor of a stack index
  function automatic ras_ptr_t ptr_prev(input ras_ptr_t p);
    if (p == '0) return ras_ptr_t'(RAS_DEPTH - 1);
    return p - 1'b1;
  endfunction
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
(
  input  logic      sel,
  input  logic      push,
  input  logic      pop,
  input  logic      fix,
  input  ras_ptr_t  ptr_q,
  input  ras_addr_t push_addr,
  input  ras_ptr_t  fix_idx,
  input  ras_addr_t fix_addr,
  output ras_ptr_t  ptr_d,
  output logic      wr_en,
  output ras_ptr_t  wr_idx,
  output ras_addr_t wr_data
);
  ras_ptr_t after_pop;

  always_comb begin
    after_pop = pop ? ptr_prev(ptr_q) : ptr_q;
    ptr_d     = ptr_q;
    wr_en     = 1'b0;
    wr_idx    = ptr_q;
    wr_data   = push_addr;
    if (sel) begin
      if (fix) begin
        ptr_d   = fix_idx;
        wr_en   = 1'b1;
        wr_idx  = fix_idx;
        wr_data = fix_addr;
      end else if (push) begin
        ptr_d   = ptr_next(after_pop);
        wr_en   = 1'b1;
        wr_idx  = ptr_next(after_pop);
      end else begin
        ptr_d   = after_pop;
      end
    end
  end
endmodule

// File: rtl/ras_store.sv
module ras_store
  import ras_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel,
  input  logic      push,
  input  logic      pop,
  input  logic      fix,
  input  ras_addr_t push_addr,
  input  ras_ptr_t  fix_idx,
  input  ras_addr_t fix_addr,
  output ras_addr_t top_addr,
  output ras_ptr_t  top_idx
);
  localparam ras_ptr_t LAST = ras_ptr_t'(RAS_DEPTH - 1);

  ras_ptr_t  ptr_q, ptr_d;
  logic      wr_en;
  ras_ptr_t  wr_idx;
  ras_addr_t wr_data;
  ras_addr_t ent_q [RAS_DEPTH];

  ras_ctrl u_ctrl (
    .sel(sel), .push(push), .pop(pop), .fix(fix), .ptr_q(ptr_q),
    .push_addr(push_addr), .fix_idx(fix_idx), .fix_addr(fix_addr),
    .ptr_d(ptr_d), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar e = 0; e < RAS_DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                ent_q[e] <= '0;
      else if (wr_en && wr_idx == ras_ptr_t'(e)) ent_q[e] <= wr_data;
    end
  end

  assign top_addr = ent_q[ptr_q];
  assign top_idx  = ptr_q;

  // R2
  push_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel && push && !pop && !fix |=>
      (($past(ptr_q) == LAST) ? (ptr_q == '0) : (ptr_q == $past(ptr_q) + 1'b1)));
  // R2
  push_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel && push && !fix |=> top_addr == $past(push_addr));
  // R3
  pop_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel && pop && !push && !fix |=>
      (($past(ptr_q) == '0) ? (ptr_q == LAST) : (ptr_q + 1'b1 == $past(ptr_q))));
  // R5
  pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel && push && pop && !fix |=> ptr_q == $past(ptr_q));
  // R6
  fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel && fix |=> ptr_q == $past(fix_idx) && top_addr == $past(fix_addr));
  // R8
  other_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(ptr_q) && $stable(top_addr));
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel && !push && !pop && !fix |=> $stable(ptr_q) && $stable(top_addr));
endmodule

// File: rtl/ras_repair_top.sv
module ras_repair_top
  import ras_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 2,
  localparam int unsigned TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TID_W-1:0]      thr_id,
  input  logic                  push_en,
  input  logic [RAS_ADDR_W-1:0] push_addr,
  input  logic                  pop_en,
  input  logic                  fix_en,
  input  logic [RAS_PTR_W-1:0]  fix_idx,
  input  logic [RAS_ADDR_W-1:0] fix_addr,
  output logic [RAS_ADDR_W-1:0] top_addr,
  output logic [RAS_PTR_W-1:0]  top_idx
);
  ras_addr_t t_addr [NUM_THREADS];
  ras_ptr_t  t_idx  [NUM_THREADS];
  logic [NUM_THREADS-1:0] thr_sel;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign thr_sel[t] = (thr_id == TID_W'(t));
    ras_store u_store (
      .clk(clk), .rst_n(rst_n), .sel(thr_sel[t]),
      .push(push_en), .pop(pop_en), .fix(fix_en),
      .push_addr(push_addr), .fix_idx(fix_idx), .fix_addr(fix_addr),
      .top_addr(t_addr[t]), .top_idx(t_idx[t])
    );
  end

  always_comb begin
    top_addr = '0;
    top_idx  = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (thr_sel[t]) begin
        top_addr = t_addr[t];
        top_idx  = t_idx[t];
      end
    end
  end

  // R8
  one_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(thr_sel));
endmodule

// File: tb/ras_repair_top_tb.sv
`timescale 1ns/1ps
module ras_repair_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [0:0]  thr_id = '0;
  logic        push_en = 1'b0, pop_en = 1'b0, fix_en = 1'b0;
  logic [31:0] push_addr = '0, fix_addr = '0;
  logic [3:0]  fix_idx = '0;
  logic [31:0] top_addr;
  logic [3:0]  top_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int          m_ptr [2];
  logic [31:0] m_mem [2][16];

  always #2.5 clk = ~clk;

  ras_repair_top dut_i (
    .clk(clk), .rst_n(rst_n), .thr_id(thr_id), .push_en(push_en),
    .push_addr(push_addr), .pop_en(pop_en), .fix_en(fix_en),
    .fix_idx(fix_idx), .fix_addr(fix_addr), .top_addr(top_addr), .top_idx(top_idx)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // one cycle: drive, check pre-op outputs (R4), then advance the model
  task automatic step(input int th, input bit pu, input logic [31:0] pa,
                      input bit po, input bit fx, input int fi,
                      input logic [31:0] fa, input string tag);
    @(negedge clk);
    thr_id = th[0:0]; push_en = pu; push_addr = pa; pop_en = po;
    fix_en = fx; fix_idx = fi[3:0]; fix_addr = fa;
    #1;
    checks++;
    if (top_idx !== m_ptr[th][3:0]) begin
      errors++;
      $display("FAIL %s thr%0d top_idx got %0d exp %0d", tag, th, top_idx, m_ptr[th]);
    end
    checks++;
    if (top_addr !== m_mem[th][m_ptr[th]]) begin
      errors++;
      $display("FAIL %s thr%0d top_addr got %h exp %h", tag, th, top_addr,
               m_mem[th][m_ptr[th]]);
    end
    @(posedge clk);
    if (fx) begin
      m_ptr[th] = fi;
      m_mem[th][fi] = fa;
    end else begin
      if (po) m_ptr[th] = (m_ptr[th] + 15) % 16;
      if (pu) begin
        m_ptr[th] = (m_ptr[th] + 1) % 16;
        m_mem[th][m_ptr[th]] = pa;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish");
    finish_run();
  end

  initial begin
    for (int t = 0; t < 2; t++) begin
      m_ptr[t] = 0;
      for (int e = 0; e < 16; e++) m_mem[t][e] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state of both threads
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, 0, "R1");
    // R2 pushes on thread 0
    step(0, 1, 32'h1000_0004, 0, 0, 0, 0, "R2");
    step(0, 1, 32'h1000_0104, 0, 0, 0, 0, "R2");
    step(0, 1, 32'h1000_0204, 0, 0, 0, 0, "R2");
    // R8 thread 1 untouched, then switch back
    step(1, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    // R4 R3 speculative pop reports pre-pop values
    step(0, 0, 0, 1, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 0, 0, 0, "R3");
    // R6 undo both pops: restore index 3 with its target
    step(0, 0, 0, 0, 1, 3, 32'h1000_0204, "R6");
    // R5 push and pop together
    step(0, 1, 32'hAAAA_0008, 1, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, "R5");
    // R6 restore wins over simultaneous push+pop
    step(0, 1, 32'hDEAD_0000, 1, 1, 9, 32'h5555_0010, "R6");
    step(0, 1, 32'hDEAD_0001, 0, 1, 2, 32'h6666_0020, "R6");
    step(0, 0, 0, 0, 0, 0, 0, "R6");
    // call undo by pop
    step(0, 1, 32'h7777_0030, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 0, 0, 0, "R3");
    // R7 overflow on thread 1
    for (int i = 0; i < 20; i++)
      step(1, 1, 32'hB000_0000 + 32'(i * 4), 0, 0, 0, 0, "R7");
    // R8 thread 0 unaffected by thread 1 overflow
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 18; i++)
      step(1, 0, 0, 1, 0, 0, 0, "R7");
    // R7 pop wrap from index 0 on thread 0
    for (int i = 0; i < 4; i++)
      step(0, 0, 0, 1, 0, 0, 0, "R7");
    // interleaved threads
    for (int i = 0; i < 24; i++)
      step(i % 2, (i % 3) != 0, 32'hC000_0000 + 32'(i), (i % 4) == 0,
           (i % 7) == 6, (i * 5) % 16, 32'hF000_0000 + 32'(i), "R8");
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    step(1, 0, 0, 0, 0, 0, 0, "R9");
    finish_run();
  end
endmodule